// File: doc/BRIEF.md
# Function Unit Operand Latch Controller

This block is the front end of a compute unit. It sits between the issue stage and an ALU. An issue pulse starts an operation. In that same cycle the block captures an active-low per-operand read enable. An operand marked as not needed counts as present from the start and is never requested. The operands that are needed are requested from the register read ports and latched as their strobes arrive. Once every needed operand is held, the block presents the operand set to the ALU with a valid flag.

The block then waits for the ALU to report completion. With that report come a result per output and a data-ok flag per output. Only outputs whose data-ok is high become write requests, and each request is held until it is acknowledged. An active-low cancel masks the ALU valid, the data-ok flags and the write requests, and returns the unit to idle. While the unit is idle every operand latch reads zero, so no stale operand can reach the ALU.

Top module: `fu_opnd_ctrl`

## Requirements
- R1: After reset, busy_o, alu_valid_o, done_o, src_req_o and wr_req_o are all zero, and alu_opnd_o reads zero.
- R2: issue_i taken while idle raises busy_o in the following cycle, not in the issue cycle itself.
- R3: rd_en_ni is sampled only in the issue cycle. Changes to it afterwards have no effect on which operands are requested.
- R4: An operand whose rd_en_ni bit is 1 at issue is never requested and counts as already satisfied. A strobe on that lane is ignored and its alu_opnd_o lane stays zero. If all operands are skipped, alu_valid_o rises in the first busy cycle.
- R5: A requested operand is latched on the first strobe of its lane, and its src_req_o bit drops in the next cycle. Later strobes on that lane leave the latched value unchanged.
- R6: alu_valid_o is high exactly while the unit is gathering, every unskipped operand is latched and cancel_ni is high. alu_opnd_o carries lane i in bits [i*DATA_W +: DATA_W].
- R7: alu_opnd_o reads zero whenever busy_o is low.
- R8: No write request is made before the ALU reports completion (alu_done_i while alu_valid_o). After completion, wr_req_o holds exactly the outputs whose alu_ok_i bit was high, and wr_data_o lane d carries the corresponding alu_res_i lane.
- R9: Each wr_req_o bit stays high until it is acknowledged on wr_ack_i. done_o is high in the cycle of the last acknowledgement, and busy_o falls in the next cycle.
- R10: If the ALU completes with all alu_ok_i bits low, done_o is high in that completion cycle, no write request is made, and busy_o falls in the next cycle.
- R11: While cancel_ni is low, alu_valid_o and wr_req_o are zero, and alu_done_i and alu_ok_i are ignored. A busy unit that sees cancel_ni low is idle in the next cycle, without done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Start an operation (taken while idle) |
| rd_en_ni | input | NUM_SRC | Per-operand read enable, active low (1 = skip), sampled at issue |
| src_strobe_i | input | NUM_SRC | Operand data present on the lane |
| src_data_i | input | NUM_SRC*DATA_W | Operand data, lane i at [i*DATA_W +: DATA_W] |
| src_req_o | output | NUM_SRC | Register read request per operand |
| alu_opnd_o | output | NUM_SRC*DATA_W | Operands presented to the ALU |
| alu_valid_o | output | 1 | All needed operands present, not cancelled |
| alu_done_i | input | 1 | ALU reports its result |
| alu_ok_i | input | NUM_DST | Per-output data-ok from the ALU |
| alu_res_i | input | NUM_DST*DATA_W | ALU results, lane d at [d*DATA_W +: DATA_W] |
| cancel_ni | input | 1 | Cancel, active low |
| busy_o | output | 1 | Unit holds an operation |
| wr_req_o | output | NUM_DST | Write-back request per output |
| wr_data_o | output | NUM_DST*DATA_W | Write-back data per output |
| wr_ack_i | input | NUM_DST | Write-back acknowledge per output |
| done_o | output | 1 | Operation completes this cycle |

## Verification
The gather path is tried with three read-enable patterns: all operands needed, a mixed skip pattern, and all skipped. Together these separate a latched mask from a live one, and an ignored strobe from a captured one. Strobes arrive out of lane order and repeat on a lane that is already filled, which catches overwrite bugs. The completion path is tried with both data-ok flags set, with none set, and with only one set, and the write acknowledgement is withheld for several cycles. Cancel is applied both while gathering and while writing back, so leaks through either the valid or the request path show up.

// File: rtl/fu_opnd_pkg.sv
package fu_opnd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GATHER = 2'd1,
    ST_WRITE  = 2'd2
  } fu_state_e;
endpackage

// File: rtl/fu_opnd_lane.sv
module fu_opnd_lane #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              got_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_o  <= 1'b0;
      data_o <= '0;
    end else if (clear_i) begin
      got_o  <= 1'b0;
      data_o <= '0;
    end else if (cap_i) begin
      got_o  <= 1'b1;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/fu_wb_track.sv
module fu_wb_track #(
  parameter int NUM_DST = 2,
  parameter int DATA_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      load_i,
  input  logic [NUM_DST-1:0]        ok_i,
  input  logic [NUM_DST*DATA_W-1:0] res_i,
  input  logic [NUM_DST-1:0]        ack_i,
  output logic [NUM_DST-1:0]        pend_o,
  output logic [NUM_DST*DATA_W-1:0] data_o,
  output logic                      empty_next_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_o <= '0;
    else if (clear_i) pend_o <= '0;
    else if (load_i)  pend_o <= ok_i;
    else              pend_o <= pend_o & ~ack_i;
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_res
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 data_o[d*DATA_W +: DATA_W] <= '0;
      else if (load_i && ok_i[d])  data_o[d*DATA_W +: DATA_W] <= res_i[d*DATA_W +: DATA_W];
    end
  end

  assign empty_next_o = ((pend_o & ~ack_i) == '0);
endmodule

// File: rtl/fu_opnd_ctrl.sv
module fu_opnd_ctrl
  import fu_opnd_pkg::*;
#(
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int DATA_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      issue_i,
  input  logic [NUM_SRC-1:0]        rd_en_ni,
  input  logic [NUM_SRC-1:0]        src_strobe_i,
  input  logic [NUM_SRC*DATA_W-1:0] src_data_i,
  output logic [NUM_SRC-1:0]        src_req_o,
  output logic [NUM_SRC*DATA_W-1:0] alu_opnd_o,
  output logic                      alu_valid_o,
  input  logic                      alu_done_i,
  input  logic [NUM_DST-1:0]        alu_ok_i,
  input  logic [NUM_DST*DATA_W-1:0] alu_res_i,
  input  logic                      cancel_ni,
  output logic                      busy_o,
  output logic [NUM_DST-1:0]        wr_req_o,
  output logic [NUM_DST*DATA_W-1:0] wr_data_o,
  input  logic [NUM_DST-1:0]        wr_ack_i,
  output logic                      done_o
);
  localparam int OPND_W = NUM_SRC * DATA_W;

  fu_state_e          state_q, state_d;
  logic [NUM_SRC-1:0] skip_q;
  logic [NUM_SRC-1:0] got;
  logic [NUM_SRC-1:0] cap;
  logic [NUM_DST-1:0] pend;
  logic               gather, writing, all_sat, accept, wb_empty_next, lane_clear;
  logic [OPND_W-1:0]  opnd;

  assign gather  = (state_q == ST_GATHER);
  assign writing = (state_q == ST_WRITE);
  assign all_sat = &(got | skip_q);
  assign accept  = alu_valid_o & alu_done_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (issue_i) state_d = ST_GATHER;
      ST_GATHER: begin
        if (!cancel_ni)  state_d = ST_IDLE;
        else if (accept) state_d = (|alu_ok_i) ? ST_WRITE : ST_IDLE;
      end
      ST_WRITE:  if (!cancel_ni || wb_empty_next) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      skip_q  <= '0;
    end else begin
      state_q <= state_d;
      // mask is captured once; later changes are not seen
      if (state_q == ST_IDLE && issue_i) skip_q <= rd_en_ni;
    end
  end

  // latches cleared on every idle cycle and on the way out
  assign lane_clear = (state_d == ST_IDLE);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
    assign cap[i] = gather & src_strobe_i[i] & ~skip_q[i] & ~got[i];
    fu_opnd_lane #(.DATA_W(DATA_W)) i_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clear_i(lane_clear),
      .cap_i  (cap[i]),
      .data_i (src_data_i[i*DATA_W +: DATA_W]),
      .got_o  (got[i]),
      .data_o (opnd[i*DATA_W +: DATA_W])
    );
  end

  fu_wb_track #(.NUM_DST(NUM_DST), .DATA_W(DATA_W)) i_wb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (state_d == ST_IDLE),
    .load_i      (accept && (state_d == ST_WRITE)),
    .ok_i        (alu_ok_i),
    .res_i       (alu_res_i),
    .ack_i       (wr_ack_i & wr_req_o),
    .pend_o      (pend),
    .data_o      (wr_data_o),
    .empty_next_o(wb_empty_next)
  );

  assign busy_o      = (state_q != ST_IDLE);
  assign src_req_o   = gather ? (~skip_q & ~got) : '0;
  assign alu_opnd_o  = opnd;
  assign alu_valid_o = gather & all_sat & cancel_ni;
  assign wr_req_o    = (writing && cancel_ni) ? pend : '0;
  assign done_o      = cancel_ni & ((accept & ~(|alu_ok_i)) | (writing & wb_empty_next));
endmodule

// File: rtl/fu_opnd_ctrl_chk.sv
module fu_opnd_ctrl_chk #(
  parameter int NUM_SRC = 3,
  parameter int NUM_DST = 2,
  parameter int DATA_W  = 16
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      issue_i,
  input logic                      busy_o,
  input logic                      cancel_ni,
  input logic                      alu_valid_o,
  input logic [NUM_SRC-1:0]        src_req_o,
  input logic [NUM_SRC-1:0]        skip_q,
  input logic [NUM_DST-1:0]        wr_req_o,
  input logic                      done_o,
  input logic [NUM_SRC*DATA_W-1:0] alu_opnd_o
);
  // R2
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && !busy_o) |=> busy_o);
  // R4
  skip_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_req_o & skip_q) == '0);
  // R6
  valid_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_valid_o |-> (cancel_ni && busy_o));
  // R7
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (alu_opnd_o == '0));
  // R9
  wr_no_new_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o != '0) |=> ((wr_req_o & ~$past(wr_req_o)) == '0));
  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R11
  cancel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cancel_ni |-> (wr_req_o == '0 && !alu_valid_o && !done_o));
  // R11
  cancel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cancel_ni && busy_o) |=> !busy_o);
endmodule

bind fu_opnd_ctrl fu_opnd_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_DST(NUM_DST), .DATA_W(DATA_W)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .issue_i    (issue_i),
  .busy_o     (busy_o),
  .cancel_ni  (cancel_ni),
  .alu_valid_o(alu_valid_o),
  .src_req_o  (src_req_o),
  .skip_q     (skip_q),
  .wr_req_o   (wr_req_o),
  .done_o     (done_o),
  .alu_opnd_o (alu_opnd_o)
);

// File: tb/test_fu_opnd_ctrl.sv
module test_fu_opnd_ctrl;
  localparam int NS = 3;
  localparam int ND = 2;
  localparam int DW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              issue = 1'b0;
  logic [NS-1:0]     rd_en_n = '0;
  logic [NS-1:0]     strobe = '0;
  logic [NS*DW-1:0]  sdata = '0;
  logic [NS-1:0]     sreq;
  logic [NS*DW-1:0]  opnd;
  logic              valid;
  logic              alu_done = 1'b0;
  logic [ND-1:0]     ok = '0;
  logic [ND*DW-1:0]  res = '0;
  logic              cancel_n = 1'b1;
  logic              busy;
  logic [ND-1:0]     wreq;
  logic [ND*DW-1:0]  wdata;
  logic [ND-1:0]     wack;
  logic              done;
  logic              ack_en = 1'b0;
  bit                finished = 1'b0;

  typedef struct { int lane; logic [DW-1:0] data; } wb_item_t;
  wb_item_t exp_q[$];

  int nvec = 0;
  int nerr = 0;

  always #2 clk = ~clk;

  assign wack = ack_en ? wreq : '0;

  fu_opnd_ctrl #(.NUM_SRC(NS), .NUM_DST(ND), .DATA_W(DW)) i_fu_opnd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .rd_en_ni(rd_en_n),
    .src_strobe_i(strobe), .src_data_i(sdata), .src_req_o(sreq),
    .alu_opnd_o(opnd), .alu_valid_o(valid), .alu_done_i(alu_done),
    .alu_ok_i(ok), .alu_res_i(res), .cancel_ni(cancel_n), .busy_o(busy),
    .wr_req_o(wreq), .wr_data_o(wdata), .wr_ack_i(wack), .done_o(done)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  task automatic push_wb(int lane, logic [DW-1:0] d);
    wb_item_t it;
    it.lane = lane;
    it.data = d;
    exp_q.push_back(it);
  endtask

  // monitor: every acknowledged request is compared against the queue
  always @(negedge clk) begin
    if (rst_n) begin
      for (int d = 0; d < ND; d++) begin
        if (wreq[d] && wack[d]) begin
          nvec++;
          if (exp_q.size() == 0) begin
            nerr++;
            $display("FAIL R8: unexpected write lane %0d data %0h expected none", d, wdata[d*DW +: DW]);
          end else begin
            wb_item_t it;
            it = exp_q.pop_front();
            if (it.lane != d || it.data !== wdata[d*DW +: DW]) begin
              nerr++;
              $display("FAIL R8: write lane %0d data %0h expected lane %0d data %0h",
                       d, wdata[d*DW +: DW], it.lane, it.data);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    smp();
    // R1
    check("R1 busy", busy, 0);
    check("R1 valid", valid, 0);
    check("R1 wreq", wreq, 0);
    check("R1 sreq", sreq, 0);
    check("R1 done", done, 0);
    check("R1 opnd", opnd, 0);
    cyc(); rst_n = 1'b1;
    cyc();

    // full gather, both outputs written, ack withheld
    issue = 1'b1; rd_en_n = 3'b000;
    smp(); check("R2 busy in issue cycle", busy, 0);
    cyc(); issue = 1'b0; rd_en_n = 3'b111;
    smp(); check("R2 busy after issue", busy, 1);
    check("R3 mask latched", sreq, 3'b111);
    check("R6 valid early", valid, 0);
    cyc(); strobe = 3'b001; sdata = {16'h0000, 16'h0000, 16'hA0A0};
    cyc(); strobe = 3'b101; sdata = {16'hC0C0, 16'h0000, 16'hEEEE};
    smp(); check("R5 req drops", sreq, 3'b110);
    cyc(); strobe = 3'b010; sdata = {16'h0000, 16'hB0B0, 16'h0000};
    smp(); check("R5 lane0 kept", opnd[DW-1:0], 16'hA0A0);
    check("R5 req lane1", sreq, 3'b010);
    check("R6 valid partial", valid, 0);
    cyc(); strobe = '0;
    alu_done = 1'b1; ok = 2'b11; res = {16'h2222, 16'h1111};
    push_wb(0, 16'h1111); push_wb(1, 16'h2222);
    smp(); check("R6 valid", valid, 1);
    check("R6 opnd", opnd, {16'hC0C0, 16'hB0B0, 16'hA0A0});
    check("R8 no early wreq", wreq, 0);
    check("R9 no early done", done, 0);
    cyc(); alu_done = 1'b0; ok = '0;
    smp(); check("R8 wreq", wreq, 2'b11);
    check("R6 valid after accept", valid, 0);
    cyc();
    smp(); check("R9 wreq held", wreq, 2'b11);
    check("R9 busy held", busy, 1);
    cyc(); ack_en = 1'b1;
    smp(); check("R9 done", done, 1);
    cyc(); ack_en = 1'b0;
    smp(); check("R9 busy falls", busy, 0);
    check("R7 opnd idle", opnd, 0);
    check("R9 wreq idle", wreq, 0);

    // mixed skip, no write
    issue = 1'b1; rd_en_n = 3'b101;
    cyc(); issue = 1'b0; rd_en_n = 3'b000;
    smp(); check("R4 req mixed", sreq, 3'b010);
    cyc(); strobe = 3'b011; sdata = {16'h0000, 16'hD0D0, 16'h5A5A};
    cyc(); strobe = '0; alu_done = 1'b1; ok = 2'b00; res = {16'hFFFF, 16'hFFFF};
    smp(); check("R4 valid mixed", valid, 1);
    check("R4 skipped lane zero", opnd, {16'h0000, 16'hD0D0, 16'h0000});
    check("R10 done", done, 1);
    check("R10 no wreq", wreq, 0);
    cyc(); alu_done = 1'b0;
    smp(); check("R10 busy falls", busy, 0);
    check("R10 wreq", wreq, 0);

    // all skipped, one output written
    issue = 1'b1; rd_en_n = 3'b111;
    cyc(); issue = 1'b0; rd_en_n = 3'b000;
    alu_done = 1'b1; ok = 2'b10; res = {16'h7777, 16'h9999}; ack_en = 1'b1;
    push_wb(1, 16'h7777);
    smp(); check("R4 valid all skipped", valid, 1);
    check("R3 no req", sreq, 3'b000);
    cyc(); alu_done = 1'b0; ok = '0;
    smp(); check("R8 single wreq", wreq, 2'b10);
    check("R9 done single", done, 1);
    cyc();
    smp(); check("R9 idle", busy, 0);

    // cancel while gathering
    issue = 1'b1; rd_en_n = 3'b000;
    cyc(); issue = 1'b0; strobe = 3'b111; sdata = {16'h3333, 16'h4444, 16'h6666};
    cyc(); strobe = '0;
    smp(); check("R6 valid before cancel", valid, 1);
    cyc(); cancel_n = 1'b0; alu_done = 1'b1; ok = 2'b11;
    smp(); check("R11 valid masked", valid, 0);
    check("R11 no done", done, 0);
    cyc(); cancel_n = 1'b1; alu_done = 1'b0; ok = '0;
    smp(); check("R11 idle", busy, 0);
    check("R11 no wreq", wreq, 0);
    check("R7 opnd cleared", opnd, 0);

    // cancel while writing back
    ack_en = 1'b0;
    issue = 1'b1;
    cyc(); issue = 1'b0; strobe = 3'b111;
    cyc(); strobe = '0; alu_done = 1'b1; ok = 2'b01; res = {16'h0000, 16'h8888};
    cyc(); alu_done = 1'b0; ok = '0;
    smp(); check("R8 wreq lane0", wreq, 2'b01);
    cyc(); cancel_n = 1'b0;
    smp(); check("R11 wreq masked", wreq, 0);
    cyc(); cancel_n = 1'b1;
    smp(); check("R11 idle after wb", busy, 0);
    check("R11 wreq after wb", wreq, 0);

    check("R8 all writes seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule